// File: doc/BRIEF.md
# Redundant Store Comparison Unit

This unit sits between two hardware threads that run the same program and the data cache. Each thread writes its committed stores into a queue of its own. The unit looks at the oldest entry of each queue and compares the two. It sends a single write to the memory port only when the addresses and the data of both entries agree. A disagreement raises a fault flag that stays set until reset. From then on the unit withholds every write and every uncached read.

The unit also pairs the uncached load requests of the two threads. An uncached read leaves the protected region only when both threads present the same address in the same cycle. Both threads then receive one shared acknowledge. Cached loads never pass through this unit, so it has no port for them.

Top module: `dual_store_checker`

## Requirements
- R1: After reset both queues are empty, `fault` is 0, `mem_wr_valid` and `mem_rd_valid` are 0, and both store ready outputs are 1.
- R2: A store accepted from one thread alone is held in that thread's queue, and `mem_wr_valid` stays 0 until the other thread supplies its store.
- R3: When both queue heads are present with equal address and equal data, `mem_wr_valid` is 1 with that address and data. A cycle with `mem_wr_ready` high removes both heads, and pairs leave in the order they were written.
- R4: When both heads are present and differ in address or in data, `mem_wr_valid` is 0 in that cycle and `fault` is 1 from the next cycle until reset. While `fault` is 1, no later pair is released.
- R5: While `mem_wr_ready` is 0, a released pair stays offered with `mem_wr_valid` 1 and the same address and data.
- R6: `mem_rd_valid` is 1, with the common address, only when both uncached load valids are 1 with equal addresses. `ul_ack` is 1 in a cycle where `mem_rd_valid` and `mem_rd_ready` are both 1. A request from one thread alone is not issued.
- R7: Two uncached load requests with different addresses issue nothing, and `fault` is 1 from the next cycle.
- R8: A conflict in either comparator withholds both the store write and the uncached read in that same cycle. When both comparators agree, both outputs may be valid in one cycle.
- R9: A thread's store ready output is 0 while its queue holds DEPTH entries. It returns to 1 after a pair drains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lead_st_valid | input | 1 | Leading thread commits a store |
| lead_st_addr | input | ADDR_W | Leading store address |
| lead_st_data | input | DATA_W | Leading store data |
| lead_st_ready | output | 1 | Leading queue has room |
| trail_st_valid | input | 1 | Trailing thread commits a store |
| trail_st_addr | input | ADDR_W | Trailing store address |
| trail_st_data | input | DATA_W | Trailing store data |
| trail_st_ready | output | 1 | Trailing queue has room |
| mem_wr_valid | output | 1 | Checked store offered to the cache |
| mem_wr_addr | output | ADDR_W | Checked store address |
| mem_wr_data | output | DATA_W | Checked store data |
| mem_wr_ready | input | 1 | Cache accepts the store |
| lead_ul_valid | input | 1 | Leading uncached load request |
| lead_ul_addr | input | ADDR_W | Leading uncached load address |
| trail_ul_valid | input | 1 | Trailing uncached load request |
| trail_ul_addr | input | ADDR_W | Trailing uncached load address |
| ul_ack | output | 1 | Uncached load pair issued |
| mem_rd_valid | output | 1 | Checked uncached read request |
| mem_rd_addr | output | ADDR_W | Checked uncached read address |
| mem_rd_ready | input | 1 | Memory accepts the uncached read |
| fault | output | 1 | Sticky mismatch flag |

## Verification
The store-pair release and the uncached-load issue can fall in the same cycle. A conflict on either path must suppress both outputs. The bench provokes this by holding a matching store pair at the queue heads while it presents an uncached load pair, first with equal addresses and then with different ones. It judges the outcome at the ports in that cycle: both valids must be high in the first case and both low in the second. It then checks that `fault` rises one edge later.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int unsigned NUM_THREADS = 2;
  localparam int unsigned LEAD_IDX    = 0;
  localparam int unsigned TRAIL_IDX   = 1;

  // Next value of the sticky fault flag.
  function automatic logic sticky_next(input logic cur, input logic st_bad,
                                       input logic ld_bad);
    return cur | st_bad | ld_bad;
  endfunction
endpackage

// File: rtl/dsc_store_fifo.sv
module dsc_store_fifo #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_word,
  input  logic         pop,
  output logic [W-1:0] head_word,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = PTR_W + 1;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fill;
  logic             do_push, do_pop;

  assign empty     = (fill == '0);
  assign full      = (fill == CNT_W'(DEPTH));
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign head_word = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R9
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R3
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/dsc_pair_compare.sv
module dsc_pair_compare #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W+DATA_W-1:0] lead_word,
  input  logic [ADDR_W+DATA_W-1:0] trail_word,
  input  logic                     both_present,
  output logic                     pair_agree,
  output logic                     pair_conflict
);
  function automatic logic words_equal(input logic [ADDR_W+DATA_W-1:0] a,
                                       input logic [ADDR_W+DATA_W-1:0] b);
    return (a[ADDR_W+DATA_W-1:DATA_W] == b[ADDR_W+DATA_W-1:DATA_W]) &&
           (a[DATA_W-1:0] == b[DATA_W-1:0]);
  endfunction

  logic same;
  assign same          = words_equal(lead_word, trail_word);
  assign pair_agree    = both_present && same;
  assign pair_conflict = both_present && !same;
endmodule

// File: rtl/dsc_load_compare.sv
module dsc_load_compare #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              lead_valid,
  input  logic [ADDR_W-1:0] lead_addr,
  input  logic              trail_valid,
  input  logic [ADDR_W-1:0] trail_addr,
  output logic              load_agree,
  output logic              load_conflict
);
  logic both;
  assign both          = lead_valid && trail_valid;
  assign load_agree    = both && (lead_addr == trail_addr);
  assign load_conflict = both && (lead_addr != trail_addr);
endmodule

// File: rtl/dual_store_checker.sv
module dual_store_checker
  import dsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lead_st_valid,
  input  logic [ADDR_W-1:0] lead_st_addr,
  input  logic [DATA_W-1:0] lead_st_data,
  output logic              lead_st_ready,
  input  logic              trail_st_valid,
  input  logic [ADDR_W-1:0] trail_st_addr,
  input  logic [DATA_W-1:0] trail_st_data,
  output logic              trail_st_ready,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ready,
  input  logic              lead_ul_valid,
  input  logic [ADDR_W-1:0] lead_ul_addr,
  input  logic              trail_ul_valid,
  input  logic [ADDR_W-1:0] trail_ul_addr,
  output logic              ul_ack,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ready,
  output logic              fault
);
  localparam int unsigned WORD_W = ADDR_W + DATA_W;

  logic [WORD_W-1:0] in_word   [NUM_THREADS];
  logic [WORD_W-1:0] head_word [NUM_THREADS];
  logic              in_valid  [NUM_THREADS];
  logic              q_empty   [NUM_THREADS];
  logic              q_full    [NUM_THREADS];
  logic              q_push    [NUM_THREADS];

  // Named internal events used by the assertions.
  logic fault_q;
  logic pair_agree, st_conflict;
  logic ld_agree, ld_conflict;
  logic hold_all, pair_pop;

  assign in_word[LEAD_IDX]   = {lead_st_addr, lead_st_data};
  assign in_word[TRAIL_IDX]  = {trail_st_addr, trail_st_data};
  assign in_valid[LEAD_IDX]  = lead_st_valid;
  assign in_valid[TRAIL_IDX] = trail_st_valid;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign q_push[t] = in_valid[t] && !q_full[t];
    dsc_store_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push[t]),
      .push_word (in_word[t]),
      .pop       (pair_pop),
      .head_word (head_word[t]),
      .empty     (q_empty[t]),
      .full      (q_full[t])
    );
  end

  assign lead_st_ready  = !q_full[LEAD_IDX];
  assign trail_st_ready = !q_full[TRAIL_IDX];

  dsc_pair_compare #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pair (
    .lead_word     (head_word[LEAD_IDX]),
    .trail_word    (head_word[TRAIL_IDX]),
    .both_present  (!q_empty[LEAD_IDX] && !q_empty[TRAIL_IDX]),
    .pair_agree    (pair_agree),
    .pair_conflict (st_conflict)
  );

  dsc_load_compare #(.ADDR_W(ADDR_W)) u_load (
    .lead_valid    (lead_ul_valid),
    .lead_addr     (lead_ul_addr),
    .trail_valid   (trail_ul_valid),
    .trail_addr    (trail_ul_addr),
    .load_agree    (ld_agree),
    .load_conflict (ld_conflict)
  );

  // Any conflict, current or recorded, blocks both outward paths.
  assign hold_all     = fault_q || st_conflict || ld_conflict;
  assign mem_wr_valid = pair_agree && !hold_all;
  assign mem_wr_addr  = head_word[LEAD_IDX][WORD_W-1:DATA_W];
  assign mem_wr_data  = head_word[LEAD_IDX][DATA_W-1:0];
  assign pair_pop     = mem_wr_valid && mem_wr_ready;

  assign mem_rd_valid = ld_agree && !hold_all;
  assign mem_rd_addr  = lead_ul_addr;
  assign ul_ack       = mem_rd_valid && mem_rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= sticky_next(fault_q, st_conflict, ld_conflict);
  end
  assign fault = fault_q;

  // R4
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q);
  // R4
  store_conflict_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_conflict |=> fault_q);
  // R7
  load_conflict_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_conflict |=> fault_q);
  // R3
  release_heads_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (head_word[LEAD_IDX] == head_word[TRAIL_IDX]));
  // R6
  read_addrs_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (lead_ul_valid && trail_ul_valid && lead_ul_addr == trail_ul_addr));
  // R5
  stalled_pair_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (!q_empty[LEAD_IDX] && $stable(mem_wr_addr) && $stable(mem_wr_data)));
  // R8
  conflict_blocks_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_conflict || ld_conflict) |-> (!mem_wr_valid && !mem_rd_valid));
endmodule

// File: tb/dual_store_checker_bench.sv
module dual_store_checker_bench;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lead_st_valid = 0, trail_st_valid = 0;
  logic [AW-1:0] lead_st_addr = '0, trail_st_addr = '0;
  logic [DW-1:0] lead_st_data = '0, trail_st_data = '0;
  logic lead_st_ready, trail_st_ready;
  logic mem_wr_valid, mem_wr_ready = 0;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic lead_ul_valid = 0, trail_ul_valid = 0;
  logic [AW-1:0] lead_ul_addr = '0, trail_ul_addr = '0;
  logic ul_ack, mem_rd_valid, mem_rd_ready = 0;
  logic [AW-1:0] mem_rd_addr;
  logic fault;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_store_checker #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_dual_store_checker (
    .clk, .rst_n,
    .lead_st_valid, .lead_st_addr, .lead_st_data, .lead_st_ready,
    .trail_st_valid, .trail_st_addr, .trail_st_data, .trail_st_ready,
    .mem_wr_valid, .mem_wr_addr, .mem_wr_data, .mem_wr_ready,
    .lead_ul_valid, .lead_ul_addr, .trail_ul_valid, .trail_ul_addr,
    .ul_ack, .mem_rd_valid, .mem_rd_addr, .mem_rd_ready, .fault
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    lead_st_valid = 0; trail_st_valid = 0; lead_ul_valid = 0; trail_ul_valid = 0;
    mem_wr_ready = 0; mem_rd_ready = 0;
    rst_n = 0; tick(); tick(); rst_n = 1; #1;
  endtask

  task automatic push_lead(input logic [AW-1:0] a, input logic [DW-1:0] d);
    lead_st_valid = 1; lead_st_addr = a; lead_st_data = d;
    tick(); lead_st_valid = 0; #1;
  endtask

  task automatic push_trail(input logic [AW-1:0] a, input logic [DW-1:0] d);
    trail_st_valid = 1; trail_st_addr = a; trail_st_data = d;
    tick(); trail_st_valid = 0; #1;
  endtask

  task automatic push_both(input logic [AW-1:0] a, input logic [DW-1:0] d);
    lead_st_valid = 1; lead_st_addr = a; lead_st_data = d;
    trail_st_valid = 1; trail_st_addr = a; trail_st_data = d;
    tick(); lead_st_valid = 0; trail_st_valid = 0; #1;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 fault", fault, 0);
    chk("R1 wr_valid", mem_wr_valid, 0);
    chk("R1 rd_valid", mem_rd_valid, 0);
    chk("R1 lead_ready", lead_st_ready, 1);
    chk("R1 trail_ready", trail_st_ready, 1);
  endtask

  task automatic t_hold_release();
    do_reset();
    push_lead(32'h100, 32'hA1);
    chk("R2 lone lead held", mem_wr_valid, 0);
    push_lead(32'h104, 32'hA2);
    chk("R2 two lead held", mem_wr_valid, 0);
    push_trail(32'h100, 32'hA1);
    chk("R3 pair offered", mem_wr_valid, 1);
    chk("R3 addr", mem_wr_addr, 32'h100);
    chk("R3 data", mem_wr_data, 32'hA1);
    tick();
    chk("R5 still offered", mem_wr_valid, 1);
    chk("R5 addr stable", mem_wr_addr, 32'h100);
    mem_wr_ready = 1; tick();
    chk("R2 second lead waits", mem_wr_valid, 0);
    push_trail(32'h104, 32'hA2);
    chk("R3 second addr", mem_wr_addr, 32'h104);
    chk("R3 second valid", mem_wr_valid, 1);
    tick();
    chk("R3 drained", mem_wr_valid, 0);
    chk("R3 no fault", fault, 0);
  endtask

  task automatic t_order();
    do_reset();
    for (int i = 0; i < 4; i++) push_both(32'h200 + 32'(i * 8), 32'hC0 + 32'(i));
    mem_wr_ready = 1; #1;
    for (int i = 0; i < 4; i++) begin
      chk("R3 order valid", mem_wr_valid, 1);
      chk("R3 order addr", mem_wr_addr, 32'h200 + 32'(i * 8));
      chk("R3 order data", mem_wr_data, 32'hC0 + 32'(i));
      tick();
    end
    chk("R3 order empty", mem_wr_valid, 0);
  endtask

  task automatic t_store_mismatch();
    do_reset();
    mem_wr_ready = 1;
    push_lead(32'h300, 32'h55);
    push_trail(32'h300, 32'h54);
    chk("R4 data mismatch withheld", mem_wr_valid, 0);
    chk("R4 fault not yet", fault, 0);
    tick();
    chk("R4 fault raised", fault, 1);
    push_both(32'h310, 32'h66);
    chk("R4 no release after fault", mem_wr_valid, 0);
    chk("R4 fault stays", fault, 1);
    do_reset();
    mem_wr_ready = 1;
    push_lead(32'h400, 32'h77);
    push_trail(32'h404, 32'h77);
    chk("R4 addr mismatch withheld", mem_wr_valid, 0);
    tick();
    chk("R4 addr mismatch fault", fault, 1);
  endtask

  task automatic t_uncached();
    do_reset();
    mem_rd_ready = 1;
    lead_ul_valid = 1; lead_ul_addr = 32'hF00; #1;
    chk("R6 lone request not issued", mem_rd_valid, 0);
    chk("R6 lone no ack", ul_ack, 0);
    trail_ul_valid = 1; trail_ul_addr = 32'hF00; #1;
    chk("R6 issued", mem_rd_valid, 1);
    chk("R6 addr", mem_rd_addr, 32'hF00);
    chk("R6 ack", ul_ack, 1);
    mem_rd_ready = 0; #1;
    chk("R6 no ack without ready", ul_ack, 0);
    trail_ul_addr = 32'hF04; #1;
    chk("R7 mismatch not issued", mem_rd_valid, 0);
    tick();
    lead_ul_valid = 0; trail_ul_valid = 0;
    chk("R7 fault", fault, 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    push_both(32'h500, 32'h11);
    mem_wr_ready = 1; mem_rd_ready = 1;
    lead_ul_valid = 1; trail_ul_valid = 1;
    lead_ul_addr = 32'hE00; trail_ul_addr = 32'hE00; #1;
    chk("R8 both valid wr", mem_wr_valid, 1);
    chk("R8 both valid rd", mem_rd_valid, 1);
    mem_wr_ready = 0; #1;
    trail_ul_addr = 32'hE08; #1;
    chk("R8 load conflict blocks store", mem_wr_valid, 0);
    chk("R8 load conflict blocks read", mem_rd_valid, 0);
    tick();
    lead_ul_valid = 0; trail_ul_valid = 0; #1;
    chk("R8 fault after conflict", fault, 1);
    chk("R8 store still withheld", mem_wr_valid, 0);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < DEPTH; i++) push_lead(32'h1000 + 32'(i * 4), 32'(i));
    chk("R9 lead full", lead_st_ready, 0);
    chk("R9 trail not full", trail_st_ready, 1);
    push_trail(32'h1000, 32'h0);
    chk("R9 pair ready", mem_wr_valid, 1);
    mem_wr_ready = 1; tick(); mem_wr_ready = 0; #1;
    chk("R9 room after drain", lead_st_ready, 1);
  endtask

  initial begin
    t_reset_state();
    t_hold_release();
    t_order();
    t_store_mismatch();
    t_uncached();
    t_same_cycle();
    t_full();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule